// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block turns a small set of peripheral power islands on and off on request from software. Software reaches it over a simple 32-bit register bus with no wait states. Before any request can act on a domain, the domain has to be claimed in an ownership register. Software then writes a one into the bit for that domain in either the switch-on request register or the switch-off request register.

For each accepted request the block runs a fixed, timed sequence on that island, driving the island's isolation and power-switch outputs. When the sequence ends, the block clears the request bit by itself, and software polls for that clear. A switch-off request is accepted only if the enable bit of every gating slot that belongs to the domain is set. One domain owns two slots, and both must allow the request.

A separate handshake register drives active-low power-down requests towards bus bridges and reads back their active-low acknowledges. Software uses it to fence off an island's bus traffic before the island is gated.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset every island is powered (`pwr_en_o` all ones), no isolation is applied (`iso_o` all zeros), every bridge request output is high, and the ownership, switch-on and switch-off registers read zero.
- R2: The ownership register at 0x0EC is read/write with bit d owning domain d; bits above the domain count read zero. A request written for a domain whose ownership bit is 0 is ignored.
- R3: Writing 1 to bit d of the switch-on register at 0x0F8 sets that bit and drives `pwr_en_o[d]` high at the same edge. `iso_o[d]` stays at its current value until the end of the sequence, where it drops. The bit clears by itself ISO_CYC+SW_CYC+SETTLE_CYC cycles after acceptance.
- R4: Writing 1 to bit d of the switch-off register at 0x104 sets the bit and raises `iso_o[d]` at the accepting edge. `pwr_en_o[d]` drops ISO_CYC cycles later, and the bit clears by itself ISO_CYC+SW_CYC+SETTLE_CYC cycles after acceptance.
- R5: A switch-off request is ignored, leaving the island powered and the bit at 0, unless bit 0 of every gating slot control of that domain is 1. Domain PAIR_DOM owns both slot SLOT_BASE+PAIR_DOM and slot SLOT_BASE+NUM_DOM.
- R6: While a domain is sequencing, any further request for that domain, in either direction, is ignored.
- R7: Domains sequence independently. Requests for several domains in one write, or in overlapping writes, each follow their own timing.
- R8: Gating slot n has its control register at 0x800+n*0x40; bit 0 is the enable and is read/write, and the other bits read zero. Its status register at 0x80C+n*0x40 reads 1 in bit 0 while the owning island is switched off. Domain d owns slot SLOT_BASE+d.
- R9: The handshake register at 0x1FC drives `bridge_req_n_o` from bits [NUM_DOM-1:0], which reset to ones. It reads `bridge_ack_n_i[d]` at bit 23+d.
- R10: Any other offset reads zero, and writing to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from paddr |
| bridge_ack_n_i | input | NUM_DOM | Active-low bridge power-down acknowledges |
| bridge_req_n_o | output | NUM_DOM | Active-low bridge power-down requests |
| pwr_en_o | output | NUM_DOM | Island power switch enable per domain |
| iso_o | output | NUM_DOM | Island isolation per domain |

## Verification
The assertions rely on bus accesses following the usual setup-then-access order, with psel held through both phases. The bridge model is assumed to echo each request onto its acknowledge after a short delay and never on its own. The stimulus drives every bus phase from tasks at the falling edge, and its bridge model is a two-stage delay of the request outputs. Switch-off requests are made both with and without the slot enables in place, and some arrive while a sequence is still running, so the enable and busy checks see both outcomes.

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter int NUM_DOM    = 4,
  parameter int SLOT_BASE  = 16,
  parameter int PAIR_DOM   = 2,
  parameter int ISO_CYC    = 2,
  parameter int SW_CYC     = 3,
  parameter int SETTLE_CYC = 4
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [11:0]        paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  input  logic [NUM_DOM-1:0] bridge_ack_n_i,
  output logic [NUM_DOM-1:0] bridge_req_n_o,
  output logic [NUM_DOM-1:0] pwr_en_o,
  output logic [NUM_DOM-1:0] iso_o
);

  localparam int NSLOT = NUM_DOM + 1;
  localparam int TOTAL = ISO_CYC + SW_CYC + SETTLE_CYC;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [11:0] A_OWN = 12'h0EC;
  localparam logic [11:0] A_ON  = 12'h0F8;
  localparam logic [11:0] A_OFF = 12'h104;
  localparam logic [11:0] A_HSK = 12'h1FC;

  logic               wr, hsk_wr, slot_area;
  logic [4:0]         slot_idx;
  logic [5:0]         slot_off;
  logic [NUM_DOM-1:0] own_q, req_up, req_dn, en_ok, hsk_q;
  logic [NSLOT-1:0]   en_q, slot_dark;
  logic               unused_bits;

  assign wr        = psel & penable & pwrite;
  assign hsk_wr    = wr && (paddr == A_HSK);
  assign slot_area = paddr[11];
  assign slot_idx  = paddr[10:6];
  assign slot_off  = paddr[5:0];
  assign unused_bits = ^pwdata[31:NUM_DOM];
  assign bridge_req_n_o = hsk_q;

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      own_q <= '0;
      hsk_q <= '1;
      en_q  <= '0;
    end else begin
      if (wr && paddr == A_OWN) own_q <= pwdata[NUM_DOM-1:0];
      if (hsk_wr)               hsk_q <= pwdata[NUM_DOM-1:0];
      for (int i = 0; i < NSLOT; i++)
        if (wr && slot_area && slot_idx == 5'(SLOT_BASE + i) && slot_off == 6'h00)
          en_q[i] <= pwdata[0];
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [CW-1:0] cnt;
    logic          busy;

    if (d == PAIR_DOM) begin : g_pair
      assign en_ok[d] = en_q[d] & en_q[NUM_DOM];
    end else begin : g_single
      assign en_ok[d] = en_q[d];
    end

    assign busy = req_up[d] | req_dn[d];

    always_ff @(posedge pclk) begin
      if (!presetn) begin
        req_up[d]   <= 1'b0;
        req_dn[d]   <= 1'b0;
        pwr_en_o[d] <= 1'b1;
        iso_o[d]    <= 1'b0;
        cnt         <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (req_dn[d] && cnt == CW'(ISO_CYC - 1)) pwr_en_o[d] <= 1'b0;
        if (cnt == CW'(TOTAL - 1)) begin
          if (req_up[d]) iso_o[d] <= 1'b0;
          req_up[d] <= 1'b0;
          req_dn[d] <= 1'b0;
          cnt       <= '0;
        end
      end else if (wr && paddr == A_ON && pwdata[d] && own_q[d]) begin
        req_up[d]   <= 1'b1;
        pwr_en_o[d] <= 1'b1;
        cnt         <= '0;
      end else if (wr && paddr == A_OFF && pwdata[d] && own_q[d] && en_ok[d]) begin
        req_dn[d] <= 1'b1;
        iso_o[d]  <= 1'b1;
        cnt       <= '0;
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_dark[s] = ~pwr_en_o[(s < NUM_DOM) ? s : PAIR_DOM];
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_OWN: prdata[NUM_DOM-1:0] = own_q;
      A_ON:  prdata[NUM_DOM-1:0] = req_up;
      A_OFF: prdata[NUM_DOM-1:0] = req_dn;
      A_HSK: begin
        prdata[NUM_DOM-1:0]  = hsk_q;
        prdata[23+:NUM_DOM]  = bridge_ack_n_i;
      end
      default: begin
        if (slot_area)
          for (int i = 0; i < NSLOT; i++)
            if (slot_idx == 5'(SLOT_BASE + i)) begin
              if (slot_off == 6'h00)      prdata[0] = en_q[i];
              else if (slot_off == 6'h0C) prdata[0] = slot_dark[i];
            end
      end
    endcase
  end

endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] up,
  input logic [N-1:0] dn,
  input logic [N-1:0] pwr,
  input logic [N-1:0] iso,
  input logic [N-1:0] en_ok,
  input logic [N-1:0] bridge_n,
  input logic         hsk_wr
);

  for (genvar d = 0; d < N; d++) begin : g_chk
    a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(up[d] && dn[d]));

    a_r4_isolate_before_off: assert property (@(posedge clk) disable iff (!rst_n)
      !iso[d] |-> pwr[d]);

    a_r5_off_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn[d]) |-> $past(en_ok[d]));

    a_r3_power_held_on: assert property (@(posedge clk) disable iff (!rst_n)
      up[d] |-> pwr[d]);

    a_r3_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up[d]) |-> !iso[d]);
  end

  a_r9_bridge_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hsk_wr) |-> $stable(bridge_n));

endmodule

bind pwr_gate_seq pwr_gate_seq_chk #(.N(NUM_DOM)) u_chk (
  .clk      (pclk),
  .rst_n    (presetn),
  .up       (req_up),
  .dn       (req_dn),
  .pwr      (pwr_en_o),
  .iso      (iso_o),
  .en_ok    (en_ok),
  .bridge_n (bridge_req_n_o),
  .hsk_wr   (hsk_wr)
);

// File: tb/test_pwr_gate_seq.sv
module test_pwr_gate_seq;
  localparam int N = 4, SB = 16, PD = 2, ISO = 2, SW = 3, ST = 4;
  localparam int TOT = ISO + SW + ST;

  logic        clk = 0, rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [N-1:0] ack_n, ack_d1, bridge_req_n, pwr_en, iso;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  pwr_gate_seq #(.NUM_DOM(N), .SLOT_BASE(SB), .PAIR_DOM(PD),
                 .ISO_CYC(ISO), .SW_CYC(SW), .SETTLE_CYC(ST)) i_pwr_gate_seq (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .bridge_ack_n_i(ack_n), .bridge_req_n_o(bridge_req_n),
    .pwr_en_o(pwr_en), .iso_o(iso));

  always #10 clk = ~clk;

  // bridge model: acknowledge follows request two cycles later
  always @(posedge clk) begin
    if (!rst_n) begin ack_d1 <= '1; ack_n <= '1; end
    else begin ack_d1 <= bridge_req_n; ack_n <= ack_d1; end
  end

  // reference model
  logic [N-1:0] m_own, m_up, m_dn, m_pwr, m_iso, m_hsk;
  logic [N:0]   m_en;
  int           m_cnt [N];
  bit           m_wr;

  function automatic logic [11:0] slot_addr(input int s);
    return 12'h800 + 12'((SB + s) * 64);
  endfunction

  function automatic bit en_all(input int d);
    return (d == PD) ? (m_en[d] && m_en[N]) : m_en[d];
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h0EC) r[N-1:0] = m_own;
    else if (a == 12'h0F8) r[N-1:0] = m_up;
    else if (a == 12'h104) r[N-1:0] = m_dn;
    else if (a == 12'h1FC) begin r[N-1:0] = m_hsk; r[23+:N] = ack_n; end
    else
      for (int s = 0; s <= N; s++) begin
        if (a == slot_addr(s)) r[0] = m_en[s];
        if (a == slot_addr(s) + 12'h00C) r[0] = !m_pwr[(s < N) ? s : PD];
      end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = '0; m_up = '0; m_dn = '0; m_pwr = '1; m_iso = '0; m_hsk = '1; m_en = '0;
      for (int d = 0; d < N; d++) m_cnt[d] = 0;
    end else begin
      m_wr = psel && penable && pwrite;
      for (int d = 0; d < N; d++) begin
        if (m_up[d] || m_dn[d]) begin
          m_cnt[d]++;
          if (m_dn[d] && m_cnt[d] == ISO) m_pwr[d] = 1'b0;
          if (m_cnt[d] == TOT) begin
            if (m_up[d]) m_iso[d] = 1'b0;
            m_up[d] = 1'b0; m_dn[d] = 1'b0;
          end
        end else if (m_wr && paddr == 12'h0F8 && pwdata[d] && m_own[d]) begin
          m_up[d] = 1'b1; m_pwr[d] = 1'b1; m_cnt[d] = 0;
        end else if (m_wr && paddr == 12'h104 && pwdata[d] && m_own[d] && en_all(d)) begin
          m_dn[d] = 1'b1; m_iso[d] = 1'b1; m_cnt[d] = 0;
        end
      end
      if (m_wr) begin
        if (paddr == 12'h0EC) m_own = pwdata[N-1:0];
        if (paddr == 12'h1FC) m_hsk = pwdata[N-1:0];
        for (int s = 0; s <= N; s++)
          if (paddr == slot_addr(s)) m_en[s] = pwdata[0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the island and bridge outputs (R3 R4 R7 R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pwr_en == m_pwr, "R7 pwr_en_o", 32'(pwr_en), 32'(m_pwr));
      chk(iso == m_iso, "R7 iso_o", 32'(iso), 32'(m_iso));
      chk(bridge_req_n == m_hsk, "R9 bridge_req_n_o", 32'(bridge_req_n), 32'(m_hsk));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = v;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag, output logic [31:0] v);
    logic [31:0] e;
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk);
    v = prdata; e = m_read(a);
    chk(prdata === e, tag, prdata, e);
    penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic finish_up;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pwr_en == 4'hF, "R1 pwr_en_o", 32'(pwr_en), 32'hF);
    chk(iso == 4'h0, "R1 iso_o", 32'(iso), 32'h0);
    chk(bridge_req_n == 4'hF, "R1 bridge_req_n_o", 32'(bridge_req_n), 32'hF);
    rd(12'h0EC, "R1 own", v);  chk(v == 0, "R1 own zero", v, 0);
    rd(12'h0F8, "R1 on", v);   chk(v == 0, "R1 on zero", v, 0);
    rd(12'h104, "R1 off", v);  chk(v == 0, "R1 off zero", v, 0);
    // R10 unmapped offsets
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, "R10 0x000", v); chk(v == 0, "R10 0x000 zero", v, 0);
    rd(12'h7FC, "R10 0x7FC", v); chk(v == 0, "R10 0x7FC zero", v, 0);
    rd(12'hC04, "R10 slot gap", v); chk(v == 0, "R10 slot gap zero", v, 0);
    // R2 ownership
    wr(12'h0F8, 32'h1);
    rd(12'h0F8, "R2 unowned on", v); chk(v == 0, "R2 unowned ignored", v, 0);
    wr(12'h0EC, 32'hFF);
    rd(12'h0EC, "R2 own", v); chk(v == 32'hF, "R2 own width", v, 32'hF);
    // R8 slot control and status
    wr(slot_addr(0), 32'hFFFF_FFFF);
    rd(slot_addr(0), "R8 ctrl", v); chk(v == 1, "R8 ctrl bit0 only", v, 1);
    rd(slot_addr(0) + 12'h00C, "R8 status", v); chk(v == 0, "R8 status on", v, 0);
    // R5 switch-off needs every enable
    wr(12'h104, 32'h2);
    rd(12'h104, "R5 off no enable", v); chk(v == 0, "R5 off ignored", v, 0);
    chk(pwr_en[1] == 1'b1, "R5 island stays on", 32'(pwr_en), 32'hF);
    wr(slot_addr(PD), 32'h1);
    wr(12'h104, 32'h4);
    rd(12'h104, "R5 pair half", v); chk(v == 0, "R5 second slot missing", v, 0);
    wr(slot_addr(N), 32'h1);
    // R9 handshake on domain 2
    wr(12'h1FC, 32'hB);
    chk(bridge_req_n == 4'hB, "R9 request low", 32'(bridge_req_n), 32'hB);
    seen = 0;
    for (int k = 0; k < 10 && !seen; k++) begin
      rd(12'h1FC, "R9 poll", v);
      if (!v[25]) seen = 1;
    end
    chk(seen, "R9 ack observed low", 32'(seen), 1);
    // R4 switch-off of the pair domain
    wr(12'h104, 32'h4);
    rd(12'h104, "R4 busy", v); chk(v == 32'h4, "R4 bit set", v, 32'h4);
    repeat (TOT + 2) @(negedge clk);
    chk(pwr_en[2] == 1'b0, "R4 switched off", 32'(pwr_en), 32'hB);
    chk(iso[2] == 1'b1, "R4 isolated", 32'(iso), 32'h4);
    rd(12'h104, "R4 cleared", v); chk(v == 0, "R4 self clear", v, 0);
    rd(slot_addr(PD) + 12'h00C, "R8 status off", v); chk(v == 1, "R8 status dark", v, 1);
    rd(slot_addr(N) + 12'h00C, "R8 pair status", v); chk(v == 1, "R8 pair status dark", v, 1);
    // R6 request while busy
    wr(12'h104, 32'h1);
    wr(12'h0F8, 32'h1);
    rd(12'h0F8, "R6 on while busy", v); chk(v[0] == 1'b0, "R6 ignored", v, 0);
    repeat (TOT + 2) @(negedge clk);
    chk(pwr_en[0] == 1'b0, "R6 off completed", 32'(pwr_en), 32'hA);
    // R3 switch-on of domain 2
    wr(12'h1FC, 32'hF);
    wr(12'h0F8, 32'h4);
    rd(12'h0F8, "R3 busy", v); chk(v == 32'h4, "R3 bit set", v, 32'h4);
    chk(pwr_en[2] == 1'b1 && iso[2] == 1'b1, "R3 on while isolated",
        {30'h0, pwr_en[2], iso[2]}, 32'h3);
    repeat (TOT + 2) @(negedge clk);
    rd(12'h0F8, "R3 cleared", v); chk(v == 0, "R3 self clear", v, 0);
    chk(iso[2] == 1'b0, "R3 released", 32'(iso), 32'h1);
    // R7 concurrent sequences
    wr(slot_addr(1), 32'h1);
    wr(slot_addr(3), 32'h1);
    wr(12'h104, 32'hA);
    wr(12'h0F8, 32'h1);
    rd(12'h104, "R7 both busy", v); chk(v == 32'hA, "R7 two off", v, 32'hA);
    repeat (TOT + 4) @(negedge clk);
    chk(pwr_en == 4'b0101, "R7 final power", 32'(pwr_en), 32'h5);
    chk(iso == 4'b1010, "R7 final isolation", 32'(iso), 32'hA);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule